// File: doc/BRIEF.md
# Token-Gated Stepping Wrapper

This block lets a small cycle-exact target circuit run on a fast host clock while only advancing its own notion of time when its token channels allow it. Every connection between the target and a neighbouring unit is a ready/valid/bits channel. Each target cycle consumes exactly one token from every input channel and produces exactly one token on every output channel. In host cycles where any input token is missing, or any consumer cannot take a token, every register in the target stays frozen. This includes the registers inside nested sub-instances.

The demo target is an accumulator with a step counter and a nested history stage that remembers the last operand it took.
- Input channel A carries an addend.
- Input channel B carries a load flag and a load value as one group.
- The accumulator value fans out to two consumers. Channel P carries the accumulator alone. Channel Q carries the accumulator together with the step count under one valid/ready pair.

The target clock is the host clock, and no clock is carried in any channel. A neighbour that feeds this wrapper, or drains it, sees a plain decoupled interface.

Top module: `tok_step_wrapper`

## Requirements
- R1: The step enable is high exactly when `a_valid`, `b_valid`, `p_ready` and `q_ready` are all high. This is a combinational relation within the same host cycle.
- R2: `a_ready` and `b_ready` both equal the step enable in every cycle, so input tokens are taken only in stepping cycles.
- R3: `p_valid` and `q_valid` both equal the step enable in every cycle, so output tokens are offered only in stepping cycles.
- R4: In a host cycle with the step enable low, the accumulator and the step count are unchanged at the next clock edge, whatever the input bits are.
- R5: At a clock edge with the step enable high, three registers update:
  - The step count becomes its old value plus one, modulo 2^CW.
  - The accumulator becomes `b_val` if `b_load` is 1. Otherwise it becomes (accumulator + `a_bits` + history) modulo 2^DW.
  - The history becomes `a_bits`.
- R6: `p_bits` and `q_acc` always carry the same accumulator value. `q_steps` carries the step count in the same token as `q_acc`.
- R7: While `rst` is high at a clock edge, the accumulator, the history and the step count are cleared to 0, regardless of the step enable.
- R8: The nested history stage freezes along with the top-level state. The history used at a step is the `a_bits` of the previous step, not a value presented during stalled cycles.
- R9: The output bits depend only on the target state and never on the current input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, also used as target clock |
| rst | input | 1 | Synchronous active-high host reset |
| a_valid | input | 1 | Channel A token present |
| a_ready | output | 1 | Channel A token taken this cycle |
| a_bits | input | DW | Channel A addend |
| b_valid | input | 1 | Channel B token present |
| b_ready | output | 1 | Channel B token taken this cycle |
| b_load | input | 1 | Channel B: load accumulator from `b_val` |
| b_val | input | DW | Channel B load value |
| p_valid | output | 1 | Channel P token offered |
| p_ready | input | 1 | Channel P consumer can accept |
| p_bits | output | DW | Channel P accumulator value |
| q_valid | output | 1 | Channel Q token offered |
| q_ready | input | 1 | Channel Q consumer can accept |
| q_acc | output | DW | Channel Q accumulator value |
| q_steps | output | CW | Channel Q step count |

## Verification
The assertions cover the handshake and the freezing on every host cycle:
- the step enable as the AND of all valids and readies;
- the readies and valids that mirror it;
- the frozen outputs after a non-stepping cycle;
- the step-count increment;
- the identical fan-out copies;
- the cleared state after reset.

Only the bench scenarios show that the accumulator value follows the arithmetic across a long run of stalls and steps. This covers the load path and the history stage, which must ignore operands offered while the target is stalled. The bench does this with an independent model that is stepped once per fire.

// File: rtl/tgw_pkg.sv
package tgw_pkg;

    // Default sizes of the demo target
    localparam int DEF_DW = 8;
    localparam int DEF_CW = 6;

    // Channel indices on the token side of the wrapper
    typedef enum int {
        IN_CH_A = 0,
        IN_CH_B = 1
    } in_chan_e;

    typedef enum int {
        OUT_CH_P = 0,
        OUT_CH_Q = 1
    } out_chan_e;

    localparam int N_IN_CH  = 2;
    localparam int N_OUT_CH = 2;

    // Operand group delivered by channel B
    typedef struct packed {
        logic               load;
        logic [DEF_DW-1:0]  val;
    } ld_group_t;

    // AND-reduction of a token-readiness vector, kept as a function so the
    // controller reads as a single intent.
    function automatic logic all_set(input logic [31:0] vec, input int n);
        logic r;
        r = 1'b1;
        for (int i = 0; i < n; i++) begin
            r = r & vec[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/tgw_fire_ctrl.sv
module tgw_fire_ctrl #(
    parameter int N_IN  = 2,
    parameter int N_OUT = 2
) (
    input  logic [N_IN-1:0]  in_valid,
    output logic [N_IN-1:0]  in_ready,
    input  logic [N_OUT-1:0] out_ready,
    output logic [N_OUT-1:0] out_valid,
    output logic             fire
);
    import tgw_pkg::*;

    localparam int N_ALL = N_IN + N_OUT;

    logic [31:0] gate_vec;

    always_comb begin
        gate_vec = '0;
        gate_vec[N_ALL-1:0] = {out_ready, in_valid};
        fire = all_set(gate_vec, N_ALL);
    end

    // Every input takes its token, and every output offers its token,
    // exactly when the target steps.
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        assign in_ready[gi] = fire;
    end
    for (genvar go = 0; go < N_OUT; go++) begin : g_out
        assign out_valid[go] = fire;
    end

endmodule

// File: rtl/tgw_hold_reg.sv
module tgw_hold_reg #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // Without a step the register feeds back its own value.
    always_comb begin
        nxt = fire ? d : q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/tgw_hist_stage.sv
module tgw_hist_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    // Nested state: the enable is passed down so it freezes as well.
    tgw_hold_reg #(.W(DW), .RST_VAL('0)) u_last (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .d    (din),
        .q    (dout)
    );

endmodule

// File: rtl/tgw_demo_target.sv
module tgw_demo_target #(
    parameter int DW = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [DW-1:0] addend,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] acc_o,
    output logic [CW-1:0] steps_o
);
    logic [DW-1:0] hist;
    logic [DW-1:0] acc_nxt;
    logic [CW-1:0] steps_nxt;

    tgw_hist_stage #(.DW(DW)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .din  (addend),
        .dout (hist)
    );

    always_comb begin
        if (ld_en) begin
            acc_nxt = ld_val;
        end else begin
            acc_nxt = acc_o + addend + hist;
        end
        steps_nxt = steps_o + CW'(1);
    end

    tgw_hold_reg #(.W(DW), .RST_VAL('0)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .d    (acc_nxt),
        .q    (acc_o)
    );

    tgw_hold_reg #(.W(CW), .RST_VAL('0)) u_steps (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .d    (steps_nxt),
        .q    (steps_o)
    );

endmodule

// File: rtl/tok_step_wrapper.sv
module tok_step_wrapper #(
    parameter int DW = tgw_pkg::DEF_DW,
    parameter int CW = tgw_pkg::DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_valid,
    output logic          a_ready,
    input  logic [DW-1:0] a_bits,
    input  logic          b_valid,
    output logic          b_ready,
    input  logic          b_load,
    input  logic [DW-1:0] b_val,
    output logic          p_valid,
    input  logic          p_ready,
    output logic [DW-1:0] p_bits,
    output logic          q_valid,
    input  logic          q_ready,
    output logic [DW-1:0] q_acc,
    output logic [CW-1:0] q_steps
);
    import tgw_pkg::*;

    logic [N_IN_CH-1:0]  in_v;
    logic [N_IN_CH-1:0]  in_r;
    logic [N_OUT_CH-1:0] out_r;
    logic [N_OUT_CH-1:0] out_v;
    logic                step;
    logic [DW-1:0]       acc;
    logic [CW-1:0]       steps;

    always_comb begin
        in_v           = '0;
        in_v[IN_CH_A]  = a_valid;
        in_v[IN_CH_B]  = b_valid;
        out_r          = '0;
        out_r[OUT_CH_P] = p_ready;
        out_r[OUT_CH_Q] = q_ready;
    end

    tgw_fire_ctrl #(.N_IN(N_IN_CH), .N_OUT(N_OUT_CH)) u_ctrl (
        .in_valid  (in_v),
        .in_ready  (in_r),
        .out_ready (out_r),
        .out_valid (out_v),
        .fire      (step)
    );

    // Target clock is the host clock; the step enable gates all state.
    tgw_demo_target #(.DW(DW), .CW(CW)) u_tgt (
        .clk     (clk),
        .rst     (rst),
        .fire    (step),
        .addend  (a_bits),
        .ld_en   (b_load),
        .ld_val  (b_val),
        .acc_o   (acc),
        .steps_o (steps)
    );

    assign a_ready = in_r[IN_CH_A];
    assign b_ready = in_r[IN_CH_B];
    assign p_valid = out_v[OUT_CH_P];
    assign q_valid = out_v[OUT_CH_Q];

    // One output port fans out to two channels with identical bits.
    assign p_bits  = acc;
    assign q_acc   = acc;
    assign q_steps = steps;

endmodule

// File: rtl/tok_step_wrapper_chk.sv
module tok_step_wrapper_chk #(
    parameter int DW = 8,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          a_valid,
    input logic          a_ready,
    input logic          b_valid,
    input logic          b_ready,
    input logic          p_valid,
    input logic          p_ready,
    input logic [DW-1:0] p_bits,
    input logic          q_valid,
    input logic          q_ready,
    input logic [DW-1:0] q_acc,
    input logic [CW-1:0] q_steps
);
    assert_fire_and_R1: assert property (@(posedge clk) disable iff (rst)
        a_ready == (a_valid && b_valid && p_ready && q_ready));

    assert_in_ready_R2: assert property (@(posedge clk) disable iff (rst)
        b_ready == a_ready);

    assert_out_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (p_valid == a_ready) && (q_valid == a_ready));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !a_ready |=> $stable(p_bits) && $stable(q_steps));

    assert_step_count_R5: assert property (@(posedge clk) disable iff (rst)
        a_ready |=> q_steps == CW'($past(q_steps) + CW'(1)));

    assert_fanout_R6: assert property (@(posedge clk) disable iff (rst)
        p_bits == q_acc);

    assert_reset_R7: assert property (@(posedge clk)
        $past(rst) |-> (p_bits == '0) && (q_steps == '0));

endmodule

bind tok_step_wrapper tok_step_wrapper_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_valid (a_valid),
    .a_ready (a_ready),
    .b_valid (b_valid),
    .b_ready (b_ready),
    .p_valid (p_valid),
    .p_ready (p_ready),
    .p_bits  (p_bits),
    .q_valid (q_valid),
    .q_ready (q_ready),
    .q_acc   (q_acc),
    .q_steps (q_steps)
);

// File: tb/tok_step_wrapper_bench.sv
module tok_step_wrapper_bench;
    localparam int DW = 8;
    localparam int CW = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic          a_valid, b_valid, p_ready, q_ready;
    logic          a_ready, b_ready, p_valid, q_valid;
    logic [DW-1:0] a_bits, b_val, p_bits, q_acc;
    logic          b_load;
    logic [CW-1:0] q_steps;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Independent model of the target state
    int acc_m, hist_m, steps_m;

    tok_step_wrapper #(.DW(DW), .CW(CW)) u_tok_step_wrapper (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_ready(a_ready), .a_bits(a_bits),
        .b_valid(b_valid), .b_ready(b_ready), .b_load(b_load), .b_val(b_val),
        .p_valid(p_valid), .p_ready(p_ready), .p_bits(p_bits),
        .q_valid(q_valid), .q_ready(q_ready), .q_acc(q_acc), .q_steps(q_steps)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit av, input bit bv, input bit pr, input bit qr,
                         input int ab, input bit ld, input int bvl);
        a_valid = av; b_valid = bv; p_ready = pr; q_ready = qr;
        a_bits = DW'(ab); b_load = ld; b_val = DW'(bvl);
    endtask

    // Checks handshake and state outputs; returns whether this cycle steps.
    task automatic check_cycle(output bit f);
        f = a_valid & b_valid & p_ready & q_ready;
        chk("R1 step enable", int'(a_ready), int'(f));
        chk("R2 b_ready", int'(b_ready), int'(f));
        chk("R3 p_valid", int'(p_valid), int'(f));
        chk("R3 q_valid", int'(q_valid), int'(f));
        chk("R4/R5/R8/R9 p_bits", int'(p_bits), acc_m);
        chk("R6 q_acc", int'(q_acc), acc_m);
        chk("R5 q_steps", int'(q_steps), steps_m);
    endtask

    task automatic model_step();
        if (b_load) acc_m = int'(b_val);
        else        acc_m = (acc_m + int'(a_bits) + hist_m) % (1 << DW);
        hist_m  = int'(a_bits);
        steps_m = (steps_m + 1) % (1 << CW);
    endtask

    task automatic random_run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            bit f;
            int r;
            @(negedge clk);
            r = int'($urandom);
            drive(r[1:0] != 0, r[3:2] != 0, r[5:4] != 0, r[7:6] != 0,
                  int'(r[15:8]), r[19:16] == 0, int'(r[27:20]));
            #1;
            check_cycle(f);
            if (f) model_step();
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit f;
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 0, 0);
        acc_m = 0; hist_m = 0; steps_m = 0;
        repeat (3) @(negedge clk);

        // Exhaustive handshake sweep during reset (R1, R2, R3, R7)
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            drive(i[0], i[1], i[2], i[3], 8'hA5, 0, 0);
            #1;
            check_cycle(f);
            chk("R7 reset steps", int'(q_steps), 0);
        end

        @(negedge clk);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);

        // Directed: stalled operands must not reach the history stage (R8)
        @(negedge clk); drive(1, 1, 1, 1, 5, 0, 0);   #1; check_cycle(f); if (f) model_step();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); drive(1, 1, 0, 1, 200, 1, 99); #1; check_cycle(f); if (f) model_step();
        end
        @(negedge clk); drive(1, 1, 1, 1, 1, 0, 0);   #1; check_cycle(f); if (f) model_step();
        @(negedge clk); drive(0, 0, 0, 0, 0, 0, 0);   #1; check_cycle(f);
        chk("R8 history after stall", int'(p_bits), 11);

        // Directed: load path (R5)
        @(negedge clk); drive(1, 1, 1, 1, 7, 1, 42);  #1; check_cycle(f); if (f) model_step();
        @(negedge clk); drive(0, 1, 1, 1, 0, 0, 0);   #1; check_cycle(f);
        chk("R5 load value", int'(p_bits), 42);

        random_run(3000);

        // Reset while the enable is high (R7)
        @(negedge clk);
        rst = 1'b1;
        drive(1, 1, 1, 1, 33, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);
        #1;
        acc_m = 0; hist_m = 0; steps_m = 0;
        chk("R7 acc cleared", int'(p_bits), 0);
        chk("R7 steps cleared", int'(q_steps), 0);

        random_run(1500);

        finished = 1;
        summary();
        $finish;
    end

endmodule